// File: doc/BRIEF.md
# SDRAM Command Spacing Enforcer

This block sits between a source of SDRAM commands and the memory command bus. It enforces the minimum cycle counts that must pass between a command and earlier commands or write data. A requested command is presented with a valid strobe. If it is legal in the current cycle, it goes onto the bus in that same cycle and ready is high. If it is not legal, ready drops, the bus carries NOP, and the source holds the request until it becomes legal.

Three events drive the spacing rules. The first is the last-write-data strobe, which applies to precharge, activate, read and burst stop. The second is a mode-register load, which applies to activate and refresh. Some windows depend on the CAS latency setting. All banks share one set of timers. The block also predicts the cycle in which the data bus goes high impedance. That cycle follows a precharge after a delay set by the CAS latency, or follows a read mask after a fixed delay.

Top module: `sdram_cmd_spacer`

## Requirements
- R1: After reset every timer is satisfied. `hiz_o` is low, `bus_cmd_o` is NOP while `cmd_valid_i` is low, and the first command of any kind is ready at once.
- R2: PRECHARGE is not ready in the cycle where `wr_last_i` is high, nor in the cycle that follows. It is ready two cycles after the strobe.
- R3: With `cas3_i` high in the strobe cycle, ACTIVE is not ready in the strobe cycle or in the four cycles that follow. It is ready five cycles after the strobe.
- R4: With `cas3_i` low in the strobe cycle, ACTIVE becomes ready four cycles after the strobe and not earlier.
- R5: After a LOAD MODE issues, ACTIVE and REFRESH are not ready in the next cycle. They are ready two cycles after it.
- R6: READ and BURST STOP are not ready in a cycle where `wr_last_i` is high, and are ready in the cycle after. WRITE is always ready. READ and WRITE may issue in consecutive cycles.
- R7: A stalled command shows ready low and NOP on the bus. A held command issues in its first legal cycle. With `cmd_valid_i` low the bus carries NOP.
- R8: `hiz_o` is high exactly CL cycles after a PRECHARGE issues, with CL = 3 when `cas3_i` is high and 2 when it is low.
- R9: `hiz_o` is high two cycles after a cycle with `dqm_i` high.
- R10: Command codes on `cmd_i` and `bus_cmd_o` are: NOP 0, ACTIVE 1, READ 2, WRITE 3, PRECHARGE 4, BURST STOP 5, LOAD MODE 6, REFRESH 7.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cmd_valid_i | input | 1 | Command request present |
| cmd_i | input | 3 | Requested command code |
| cas3_i | input | 1 | CAS latency: 1 = 3, 0 = 2 |
| wr_last_i | input | 1 | Last write data beat in this cycle |
| dqm_i | input | 1 | Read data mask in this cycle |
| cmd_ready_o | output | 1 | Requested command is legal this cycle |
| bus_cmd_o | output | 3 | Command driven to memory (NOP when not issuing) |
| hiz_o | output | 1 | Predicted data bus high-impedance cycle |

## Verification
Ready and the bus command are combinational from the inputs and the timer state. The bench therefore drives each cycle's inputs after the falling edge, waits 1 ns and samples in the same cycle. `hiz_o` is registered. It is due CL rising edges after a precharge, or two edges after a mask. The vector table lists it in the row for that later cycle, so it is sampled there. The timer windows are counted from the strobe or load cycle, with the first legal cycle at offset 2, 4, 5 or 2. Each window is probed at its last blocked offset and again at its first legal offset.

// File: rtl/sdram_spc_pkg.sv
package sdram_spc_pkg;
  typedef enum logic [2:0] {
    CMD_NOP = 3'd0,
    CMD_ACT = 3'd1,
    CMD_RD  = 3'd2,
    CMD_WR  = 3'd3,
    CMD_PRE = 3'd4,
    CMD_BST = 3'd5,
    CMD_LMR = 3'd6,
    CMD_REF = 3'd7
  } cmd_e;

  localparam int TM_PRE = 0;
  localparam int TM_ACT = 1;
  localparam int TM_MRD = 2;
  localparam int NUM_TM = 3;
endpackage

// File: rtl/spc_timer.sv
module spc_timer #(
  parameter int W = 3
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic [W-1:0] load_val_i,
  output logic         busy_o
);
  logic [W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          cnt_q <= '0;
    else if (load_i)      cnt_q <= load_val_i;
    else if (cnt_q != '0) cnt_q <= cnt_q - 1'b1;
  end

  assign busy_o = (cnt_q != '0);

  p_load_busy_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i && (load_val_i != '0) |=> busy_o);
endmodule

// File: rtl/spc_hiz_pipe.sv
module spc_hiz_pipe #(
  parameter int D = 3
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [D-1:0] set_i,
  output logic         hiz_o
);
  // bit k marks a high-Z cycle k+1 edges ahead
  logic [D-1:0] pipe_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pipe_q <= '0;
    else         pipe_q <= (pipe_q >> 1) | set_i;
  end

  assign hiz_o = pipe_q[0];

  p_hiz_needs_set_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (set_i == '0) && (pipe_q[D-1:1] == '0) |=> !hiz_o);
endmodule

// File: rtl/sdram_cmd_spacer.sv
module sdram_cmd_spacer
  import sdram_spc_pkg::*;
#(
  parameter int T_DPL     = 2,
  parameter int T_DAL_CL3 = 5,
  parameter int T_DAL_CL2 = 4,
  parameter int T_MRD     = 2,
  parameter int T_DQZ     = 2,
  parameter int MAX_CL    = 3
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       cmd_valid_i,
  input  logic [2:0] cmd_i,
  input  logic       cas3_i,
  input  logic       wr_last_i,
  input  logic       dqm_i,
  output logic       cmd_ready_o,
  output logic [2:0] bus_cmd_o,
  output logic       hiz_o
);
  localparam int T_MAX = (T_DAL_CL3 > T_DPL) ?
                         ((T_DAL_CL3 > T_MRD) ? T_DAL_CL3 : T_MRD) :
                         ((T_DPL > T_MRD) ? T_DPL : T_MRD);
  localparam int TW    = (T_MAX > 2) ? $clog2(T_MAX) : 1;
  localparam int HZ_D  = (MAX_CL > T_DQZ) ? MAX_CL : T_DQZ;

  cmd_e        cmd;
  logic        legal, issue;
  logic [NUM_TM-1:0] tm_load, tm_busy;
  logic [TW-1:0]     tm_val [NUM_TM];
  logic [HZ_D-1:0]   hz_set;

  assign cmd = cmd_e'(cmd_i);

  always_comb begin
    unique case (cmd)
      CMD_ACT:          legal = !wr_last_i && !tm_busy[TM_ACT] && !tm_busy[TM_MRD];
      CMD_REF:          legal = !tm_busy[TM_MRD];
      CMD_PRE:          legal = !wr_last_i && !tm_busy[TM_PRE];
      CMD_RD, CMD_BST:  legal = !wr_last_i;
      default:          legal = 1'b1; // NOP, WRITE, LOAD MODE
    endcase
  end

  assign cmd_ready_o = legal;
  assign issue       = cmd_valid_i && legal;
  assign bus_cmd_o   = issue ? cmd_i : CMD_NOP;

  always_comb begin
    tm_load[TM_PRE] = wr_last_i;
    tm_val[TM_PRE]  = TW'(T_DPL - 1);
    tm_load[TM_ACT] = wr_last_i;
    tm_val[TM_ACT]  = cas3_i ? TW'(T_DAL_CL3 - 1) : TW'(T_DAL_CL2 - 1);
    tm_load[TM_MRD] = issue && (cmd == CMD_LMR);
    tm_val[TM_MRD]  = TW'(T_MRD - 1);
  end

  for (genvar g = 0; g < NUM_TM; g++) begin : g_tm
    spc_timer #(.W(TW)) u_tm (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .load_i     (tm_load[g]),
      .load_val_i (tm_val[g]),
      .busy_o     (tm_busy[g])
    );
  end

  logic pre_iss;
  assign pre_iss = issue && (cmd == CMD_PRE);

  always_comb begin
    hz_set = '0;
    if (pre_iss) begin
      if (cas3_i) hz_set[2] = 1'b1;
      else        hz_set[1] = 1'b1;
    end
    if (dqm_i) hz_set[T_DQZ-1] = 1'b1;
  end

  spc_hiz_pipe #(.D(HZ_D)) u_hiz (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .set_i  (hz_set),
    .hiz_o  (hiz_o)
  );

  p_pre_gap_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_cmd_o == CMD_PRE) |-> !wr_last_i && !$past(wr_last_i));

  p_act_dal_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_cmd_o == CMD_ACT) |-> !wr_last_i && !$past(wr_last_i) &&
                               !$past(wr_last_i, 2) && !$past(wr_last_i, 3));

  p_act_mrd_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_cmd_o == CMD_ACT || bus_cmd_o == CMD_REF) |-> $past(bus_cmd_o) != CMD_LMR);

  p_write_free_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_i == CMD_WR) |-> cmd_ready_o);

  p_stall_nop_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(cmd_valid_i && cmd_ready_o) |-> bus_cmd_o == CMD_NOP);

  p_hiz_src_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hiz_o |-> ($past(pre_iss, 3) && $past(cas3_i, 3)) ||
              ($past(pre_iss, 2) && !$past(cas3_i, 2)) || $past(dqm_i, 2));
endmodule

// File: tb/sim_sdram_cmd_spacer.sv
module sim_sdram_cmd_spacer;
  import sdram_spc_pkg::*;

  logic clk = 1'b0, rst_ni = 1'b0;
  logic cmd_valid_i = 1'b0, cas3_i = 1'b1, wr_last_i = 1'b0, dqm_i = 1'b0;
  logic [2:0] cmd_i = 3'd0;
  logic cmd_ready_o, hiz_o;
  logic [2:0] bus_cmd_o;
  int n_run = 0, n_fail = 0;

  always #4 clk = ~clk;

  sdram_cmd_spacer u0 (.*, .clk_i(clk));

  typedef struct packed {
    logic [2:0] cmd; logic v; logic cl3; logic wl; logic dqm;
    logic rdy; logic [2:0] bus; logic hz; logic [3:0] rq;
  } vec_t;

  localparam vec_t VEC [20] = '{
    '{3'd1,1'b1,1'b1,1'b0,1'b0, 1'b1,3'd1,1'b0, 4'd1},  // R1 first ACT at once
    '{3'd3,1'b1,1'b1,1'b1,1'b0, 1'b1,3'd3,1'b0, 4'd6},  // R6 WRITE with strobe
    '{3'd4,1'b1,1'b1,1'b0,1'b0, 1'b0,3'd0,1'b0, 4'd2},  // R2 PRE one after strobe
    '{3'd4,1'b1,1'b1,1'b0,1'b0, 1'b1,3'd4,1'b0, 4'd2},  // R2 PRE two after strobe
    '{3'd1,1'b1,1'b1,1'b0,1'b0, 1'b0,3'd0,1'b0, 4'd3},  // R3 ACT stalled
    '{3'd1,1'b1,1'b1,1'b0,1'b0, 1'b0,3'd0,1'b0, 4'd3},  // R3 ACT stalled (+4)
    '{3'd1,1'b1,1'b1,1'b0,1'b0, 1'b1,3'd1,1'b1, 4'd3},  // R3 ACT +5; R8 hiz CL3
    '{3'd2,1'b1,1'b1,1'b0,1'b0, 1'b1,3'd2,1'b0, 4'd6},
    '{3'd2,1'b1,1'b1,1'b0,1'b1, 1'b1,3'd2,1'b0, 4'd6},  // R6 back-to-back READ
    '{3'd3,1'b1,1'b1,1'b1,1'b0, 1'b1,3'd3,1'b0, 4'd6},
    '{3'd2,1'b1,1'b1,1'b0,1'b0, 1'b1,3'd2,1'b1, 4'd9},  // R6 READ after strobe; R9
    '{3'd5,1'b1,1'b1,1'b0,1'b0, 1'b1,3'd5,1'b0, 4'd6},  // R6 BST
    '{3'd4,1'b1,1'b0,1'b0,1'b0, 1'b1,3'd4,1'b0, 4'd2},  // R2 PRE at CL2
    '{3'd1,1'b1,1'b0,1'b0,1'b0, 1'b0,3'd0,1'b0, 4'd3},  // R3 window from CL3 strobe
    '{3'd1,1'b1,1'b1,1'b0,1'b0, 1'b1,3'd1,1'b1, 4'd8},  // R8 hiz at CL2
    '{3'd6,1'b1,1'b1,1'b0,1'b0, 1'b1,3'd6,1'b0, 4'd5},  // R5 LOAD MODE
    '{3'd7,1'b1,1'b1,1'b0,1'b0, 1'b0,3'd0,1'b0, 4'd5},  // R5 REF stalled
    '{3'd7,1'b1,1'b1,1'b0,1'b0, 1'b1,3'd7,1'b0, 4'd5},  // R5 REF legal
    '{3'd1,1'b0,1'b1,1'b0,1'b0, 1'b1,3'd0,1'b0, 4'd7},  // R7 valid low -> NOP
    '{3'd0,1'b1,1'b1,1'b0,1'b0, 1'b1,3'd0,1'b0, 4'd10}  // R10 NOP code 0
  };

  task automatic chk(input int rq, input string what, input int act, input int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL R%0d %s actual=%0d expected=%0d", rq, what, act, exp);
    end
  endtask

  task automatic drive(input logic [2:0] c, input logic v, input logic cl3,
                       input logic wl, input logic dq);
    cmd_i = c; cmd_valid_i = v; cas3_i = cl3; wr_last_i = wl; dqm_i = dq;
  endtask

  initial begin
    #1_000_000;
    n_fail++;
    $display("FAIL R0 watchdog actual=hung expected=done");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    // R1 reset state
    #3;
    chk(1, "hiz in reset", hiz_o, 0);
    chk(1, "bus in reset", bus_cmd_o, 0);
    @(negedge clk); rst_ni = 1'b1;

    foreach (VEC[i]) begin
      @(negedge clk);
      drive(VEC[i].cmd, VEC[i].v, VEC[i].cl3, VEC[i].wl, VEC[i].dqm);
      #1;
      chk(VEC[i].rq, $sformatf("vec%0d ready", i), cmd_ready_o, VEC[i].rdy);
      chk(VEC[i].rq, $sformatf("vec%0d bus", i), bus_cmd_o, VEC[i].bus);
      chk(VEC[i].rq, $sformatf("vec%0d hiz", i), hiz_o, VEC[i].hz);
    end

    // R6/R2 same-cycle strobe blocks READ, PRE, ACT; CL2 for R4
    @(negedge clk);
    drive(CMD_RD, 1'b1, 1'b0, 1'b1, 1'b0); #1;
    chk(6, "READ with strobe ready", cmd_ready_o, 0);
    chk(6, "READ with strobe bus", bus_cmd_o, 0);
    drive(CMD_PRE, 1'b1, 1'b0, 1'b1, 1'b0); #1;
    chk(2, "PRE with strobe ready", cmd_ready_o, 0);
    drive(CMD_ACT, 1'b1, 1'b0, 1'b1, 1'b0); #1;
    chk(4, "ACT with strobe ready", cmd_ready_o, 0);
    @(negedge clk);
    drive(CMD_RD, 1'b1, 1'b0, 1'b0, 1'b0); #1;
    chk(6, "READ after strobe bus", bus_cmd_o, 2);
    @(negedge clk);
    drive(CMD_PRE, 1'b0, 1'b0, 1'b0, 1'b0); #1;
    chk(2, "PRE +2 ready", cmd_ready_o, 1);
    drive(CMD_ACT, 1'b1, 1'b0, 1'b0, 1'b0); #1;
    chk(4, "ACT +2 ready CL2", cmd_ready_o, 0);
    @(negedge clk); #1;
    chk(4, "ACT +3 ready CL2", cmd_ready_o, 0);
    @(negedge clk); #1;
    chk(4, "ACT +4 ready CL2", cmd_ready_o, 1);
    chk(4, "ACT +4 bus CL2", bus_cmd_o, 1);

    // R1 reset clears busy timers and the hiz pipe
    @(negedge clk);
    drive(CMD_PRE, 1'b1, 1'b1, 1'b0, 1'b0); #1;
    chk(8, "PRE issue before reset", bus_cmd_o, 4);
    @(negedge clk);
    drive(CMD_WR, 1'b1, 1'b1, 1'b1, 1'b0);
    @(negedge clk);
    drive(CMD_NOP, 1'b0, 1'b1, 1'b0, 1'b0);
    rst_ni = 1'b0; #1;
    chk(1, "hiz after reset", hiz_o, 0);
    @(negedge clk); rst_ni = 1'b1;
    drive(CMD_PRE, 1'b0, 1'b1, 1'b0, 1'b0); #1;
    chk(1, "PRE ready after reset", cmd_ready_o, 1);
    drive(CMD_ACT, 1'b0, 1'b1, 1'b0, 1'b0); #1;
    chk(1, "ACT ready after reset", cmd_ready_o, 1);
    for (int k = 0; k < 3; k++) begin
      @(negedge clk); #1;
      chk(1, "hiz stays low after reset", hiz_o, 0);
    end

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule